// File: doc/BRIEF.md
# CAN Receive Mailbox Bank

This block holds a bank of receive mailboxes inside a CAN controller. A frame-level receiver hands it frames that are already decoded: extended-format flag, remote-request flag, identifier, length code and eight data bytes. Each frame is placed in the lowest-numbered mailbox that is set up for reception and is currently empty. A filled mailbox keeps its frame until host software releases it by writing a bitmask. Releasing mailboxes as a group is how software keeps a run of mailboxes in order.

Any mailbox can be put into an overwrite variant of receive mode. When every ordinary receive mailbox is full, a full overwrite mailbox still takes the newest frame and raises a flag saying an unread frame was lost. When no mailbox can take a frame at all, the frame is discarded and a sticky lost-frame output is raised.

The host reads each mailbox through a combinational register port. The registers are the mode register, the identifier, the status and two data words. A per-mailbox ready vector gives the fill state of the whole bank at once.

Top module: `can_rx_mailbox_bank`

## Requirements
- R1: After reset every mailbox mode reads 0 (disabled), `ready_vec` is all zeros and `lost_flag` is 0.
- R2: A frame presented with `frm_valid` on a clock edge is stored at that edge in the lowest-numbered mailbox that is eligible and not ready. Its ready bit is visible after that edge.
- R3: The mode field sits in bits 26:24 of the mode register: 0 disabled, 1 receive, 2 receive-with-overwrite, 3 transmit. Only modes 1 and 2 are ever chosen for reception.
- R4: The identifier register is encoded by frame format. For an extended frame, bit 29 is 1 and bits 28:0 hold the 29-bit identifier. For a standard frame, bit 29 is 0, the 11-bit identifier sits in bits 28:18 and all other bits are 0.
- R5: The status register holds the length code in bits 19:16, the remote flag in bit 20, ready in bit 23 and message-ignored in bit 24. The data-low word holds bytes 0 to 3 and the data-high word holds bytes 4 to 7.
- R6: A ready mailbox is never chosen while a free eligible mailbox exists. Its contents do not change until it is re-armed.
- R7: A cycle with `arm_valid` clears, at that edge, the ready bit and message-ignored flag of every mailbox whose bit is set in `arm_mask`. Several bits may be set at once.
- R8: If no eligible mailbox is free, the frame replaces the contents of the lowest-numbered ready mailbox in mode 2. That mailbox's message-ignored flag is set, and `lost_flag` does not change.
- R9: If no mailbox can take a frame, the frame is dropped. No mailbox changes, and `lost_flag` becomes 1 and stays 1 until reset.
- R10: Bit i of `ready_vec` equals the ready bit (status bit 23) of mailbox i.
- R11: A frame fills at most one mailbox. Without a frame, no ready bit rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Decoded frame present this cycle |
| frm_ext | input | 1 | Frame uses the 29-bit identifier |
| frm_rtr | input | 1 | Remote request frame |
| frm_id | input | 29 | Identifier; standard frames use bits 10:0 |
| frm_dlc | input | 4 | Length code |
| frm_data_lo | input | 32 | Data bytes 0 to 3 |
| frm_data_hi | input | 32 | Data bytes 4 to 7 |
| mode_wr | input | 1 | Write the mode register of one mailbox |
| mode_idx | input | IDX_W | Mailbox addressed by the mode write |
| mode_wdata | input | 32 | Mode write data, mode in bits 26:24 |
| arm_valid | input | 1 | Re-arm command strobe |
| arm_mask | input | NUM_MB | Mailboxes to re-arm, one bit each |
| rd_idx | input | IDX_W | Mailbox addressed by the read port |
| rd_sel | input | 3 | 0 mode, 1 identifier, 2 status, 3 data low, 4 data high |
| rd_data | output | 32 | Combinational read data |
| ready_vec | output | NUM_MB | Ready bit of every mailbox |
| lost_flag | output | 1 | Sticky dropped-frame flag |

## Verification
The assertions check on every cycle the properties that can be stated at the ports:
- a re-arm leaves the selected ready bits low after the edge;
- no ready bit rises without a frame;
- one frame never fills two mailboxes;
- the lost flag is sticky and rises only together with a frame.

Lowest-free placement, skipping of disabled and transmit mailboxes, the register encodings and the overwrite path need known stimulus and expected register contents. Only the directed scenarios can show these. The bench reads the registers back and compares them with values worked out by hand.

// File: rtl/can_rxmb_pkg.sv
package can_rxmb_pkg;
   localparam int REG_W     = 32;
   localparam int MODE_W    = 3;
   localparam int MODE_LSB  = 24;

   localparam logic [MODE_W-1:0] MODE_OFF    = 3'd0;
   localparam logic [MODE_W-1:0] MODE_RX     = 3'd1;
   localparam logic [MODE_W-1:0] MODE_RX_OVR = 3'd2;
   localparam logic [MODE_W-1:0] MODE_TX     = 3'd3;

   typedef enum logic [2:0] {
      SEL_MODE   = 3'd0,
      SEL_ID     = 3'd1,
      SEL_STATUS = 3'd2,
      SEL_DLO    = 3'd3,
      SEL_DHI    = 3'd4
   } rd_sel_e;

   typedef struct packed {
      logic        ext;
      logic        rtr;
      logic [28:0] id;
      logic [3:0]  dlc;
      logic [31:0] lo;
      logic [31:0] hi;
   } rx_frame_t;
endpackage

// File: rtl/rxmb_pick.sv
module rxmb_pick
   import can_rxmb_pkg::*;
#(
   parameter int NUM_MB    = 12,
   parameter bit ALLOW_OVR = 1'b1
) (
   input  logic [NUM_MB-1:0][MODE_W-1:0] mode,
   input  logic [NUM_MB-1:0]             ready,
   output logic [NUM_MB-1:0]             sel,
   output logic                          hit
);
   logic [NUM_MB-1:0] free_v;
   logic [NUM_MB-1:0] ovr_v;
   logic [NUM_MB-1:0] free_pick;
   logic [NUM_MB-1:0] ovr_pick;

   for (genvar i = 0; i < NUM_MB; i++) begin : g_elig
      assign free_v[i] = ((mode[i] == MODE_RX) || (mode[i] == MODE_RX_OVR)) && !ready[i];
   end

   if (ALLOW_OVR) begin : g_ovr
      for (genvar i = 0; i < NUM_MB; i++) begin : g_bit
         assign ovr_v[i] = (mode[i] == MODE_RX_OVR) && ready[i];
      end
   end else begin : g_no_ovr
      assign ovr_v = '0;
   end

   always_comb begin
      logic found;
      free_pick = '0;
      found     = 1'b0;
      for (int i = 0; i < NUM_MB; i++) begin
         if (free_v[i] && !found) begin
            free_pick[i] = 1'b1;
            found        = 1'b1;
         end
      end
   end

   always_comb begin
      logic found;
      ovr_pick = '0;
      found    = 1'b0;
      for (int i = 0; i < NUM_MB; i++) begin
         if (ovr_v[i] && !found) begin
            ovr_pick[i] = 1'b1;
            found       = 1'b1;
         end
      end
   end

   assign sel = (|free_v) ? free_pick : ovr_pick;
   assign hit = |sel;
endmodule

// File: rtl/rxmb_slot.sv
module rxmb_slot
   import can_rxmb_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 store,
   input  logic                 rearm,
   input  logic                 mode_we,
   input  logic [MODE_W-1:0]    mode_wval,
   input  rx_frame_t            frame,
   output logic [MODE_W-1:0]    mode,
   output logic                 ready,
   output logic [REG_W-1:0]     id_reg,
   output logic [REG_W-1:0]     stat_reg,
   output logic [REG_W-1:0]     lo_reg,
   output logic [REG_W-1:0]     hi_reg
);
   logic       ignored;
   logic       rtr_q;
   logic [3:0] dlc_q;
   logic [REG_W-1:0] id_enc;

   assign id_enc = frame.ext ? {2'b00, 1'b1, frame.id}
                             : {2'b00, 1'b0, frame.id[10:0], 18'd0};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= MODE_OFF;
         ready   <= 1'b0;
         ignored <= 1'b0;
         rtr_q   <= 1'b0;
         dlc_q   <= '0;
         id_reg  <= '0;
         lo_reg  <= '0;
         hi_reg  <= '0;
      end else begin
         if (mode_we) begin
            mode <= mode_wval;
         end
         if (store) begin
            ready   <= 1'b1;
            ignored <= ready && !rearm;
            rtr_q   <= frame.rtr;
            dlc_q   <= frame.dlc;
            id_reg  <= id_enc;
            lo_reg  <= frame.lo;
            hi_reg  <= frame.hi;
         end else if (rearm) begin
            ready   <= 1'b0;
            ignored <= 1'b0;
         end
      end
   end

   assign stat_reg = {7'd0, ignored, ready, 2'b00, rtr_q, dlc_q, 16'd0};
endmodule

// File: rtl/rxmb_rdmux.sv
module rxmb_rdmux
   import can_rxmb_pkg::*;
#(
   parameter int NUM_MB = 12,
   parameter int IDX_W  = 4
) (
   input  logic [IDX_W-1:0]              rd_idx,
   input  logic [2:0]                    rd_sel,
   input  logic [NUM_MB-1:0][MODE_W-1:0] mode,
   input  logic [NUM_MB-1:0][REG_W-1:0]  id_regs,
   input  logic [NUM_MB-1:0][REG_W-1:0]  stat_regs,
   input  logic [NUM_MB-1:0][REG_W-1:0]  lo_regs,
   input  logic [NUM_MB-1:0][REG_W-1:0]  hi_regs,
   output logic [REG_W-1:0]              rd_data
);
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_MB; i++) begin
         if (int'(rd_idx) == i) begin
            case (rd_sel)
               SEL_MODE:   rd_data = {{(REG_W-MODE_LSB-MODE_W){1'b0}}, mode[i], {MODE_LSB{1'b0}}};
               SEL_ID:     rd_data = id_regs[i];
               SEL_STATUS: rd_data = stat_regs[i];
               SEL_DLO:    rd_data = lo_regs[i];
               SEL_DHI:    rd_data = hi_regs[i];
               default:    rd_data = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/can_rx_mailbox_bank.sv
module can_rx_mailbox_bank
   import can_rxmb_pkg::*;
#(
   parameter int NUM_MB    = 12,
   parameter bit ALLOW_OVR = 1'b1,
   localparam int IDX_W    = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   input  logic              frm_ext,
   input  logic              frm_rtr,
   input  logic [28:0]       frm_id,
   input  logic [3:0]        frm_dlc,
   input  logic [31:0]       frm_data_lo,
   input  logic [31:0]       frm_data_hi,
   input  logic              mode_wr,
   input  logic [IDX_W-1:0]  mode_idx,
   input  logic [31:0]       mode_wdata,
   input  logic              arm_valid,
   input  logic [NUM_MB-1:0] arm_mask,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [2:0]        rd_sel,
   output logic [31:0]       rd_data,
   output logic [NUM_MB-1:0] ready_vec,
   output logic              lost_flag
);
   if (NUM_MB < 1 || NUM_MB > REG_W) begin : g_bad_num_mb
      $error("NUM_MB must lie between 1 and the register width");
   end

   rx_frame_t frame;
   assign frame = '{ext: frm_ext, rtr: frm_rtr, id: frm_id, dlc: frm_dlc,
                    lo: frm_data_lo, hi: frm_data_hi};

   logic [NUM_MB-1:0][MODE_W-1:0] mode_q;
   logic [NUM_MB-1:0][REG_W-1:0]  id_q, st_q, lo_q, hi_q;
   logic [NUM_MB-1:0]             pick;
   logic                          pick_hit;

   rxmb_pick #(.NUM_MB(NUM_MB), .ALLOW_OVR(ALLOW_OVR)) u_pick (
      .mode  (mode_q),
      .ready (ready_vec),
      .sel   (pick),
      .hit   (pick_hit)
   );

   for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
      rxmb_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .store     (frm_valid && pick[i]),
         .rearm     (arm_valid && arm_mask[i]),
         .mode_we   (mode_wr && (int'(mode_idx) == i)),
         .mode_wval (mode_wdata[MODE_LSB +: MODE_W]),
         .frame     (frame),
         .mode      (mode_q[i]),
         .ready     (ready_vec[i]),
         .id_reg    (id_q[i]),
         .stat_reg  (st_q[i]),
         .lo_reg    (lo_q[i]),
         .hi_reg    (hi_q[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lost_flag <= 1'b0;
      end else if (frm_valid && !pick_hit) begin
         lost_flag <= 1'b1;
      end
   end

   rxmb_rdmux #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_rdmux (
      .rd_idx    (rd_idx),
      .rd_sel    (rd_sel),
      .mode      (mode_q),
      .id_regs   (id_q),
      .stat_regs (st_q),
      .lo_regs   (lo_q),
      .hi_regs   (hi_q),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/rxmb_checker.sv
module rxmb_checker #(
   parameter int NUM_MB = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_valid,
   input logic              arm_valid,
   input logic [NUM_MB-1:0] arm_mask,
   input logic [NUM_MB-1:0] ready_vec,
   input logic              lost_flag
);
   assert_rearm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_valid && !frm_valid) |=> ((ready_vec & $past(arm_mask)) == '0));

   assert_single_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ready_vec & ~$past(ready_vec)) <= 1);

   assert_no_fill_without_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> ((ready_vec & ~$past(ready_vec)) == '0));

   assert_lost_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lost_flag |=> lost_flag);

   assert_lost_needs_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lost_flag) |-> $past(frm_valid));
endmodule

bind can_rx_mailbox_bank rxmb_checker #(.NUM_MB(NUM_MB)) u_rxmb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .frm_valid (frm_valid),
   .arm_valid (arm_valid),
   .arm_mask  (arm_mask),
   .ready_vec (ready_vec),
   .lost_flag (lost_flag)
);

// File: tb/test_can_rx_mailbox_bank.sv
module test_can_rx_mailbox_bank;
   localparam int NMB = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
   logic [28:0] frm_id = '0;
   logic [3:0]  frm_dlc = '0;
   logic [31:0] frm_data_lo = '0, frm_data_hi = '0;
   logic        mode_wr = 1'b0;
   logic [3:0]  mode_idx = '0;
   logic [31:0] mode_wdata = '0;
   logic        arm_valid = 1'b0;
   logic [NMB-1:0] arm_mask = '0;
   logic [3:0]  rd_idx = '0;
   logic [2:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic [NMB-1:0] ready_vec;
   logic        lost_flag;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   can_rx_mailbox_bank #(.NUM_MB(NMB)) i_can_rx_mailbox_bank (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ext(frm_ext),
      .frm_rtr(frm_rtr), .frm_id(frm_id), .frm_dlc(frm_dlc),
      .frm_data_lo(frm_data_lo), .frm_data_hi(frm_data_hi),
      .mode_wr(mode_wr), .mode_idx(mode_idx), .mode_wdata(mode_wdata),
      .arm_valid(arm_valid), .arm_mask(arm_mask), .rd_idx(rd_idx),
      .rd_sel(rd_sel), .rd_data(rd_data), .ready_vec(ready_vec),
      .lost_flag(lost_flag)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic send(input logic ext, input logic rtr, input logic [28:0] id,
                       input logic [3:0] dlc, input logic [31:0] lo, input logic [31:0] hi);
      @(negedge clk);
      frm_ext = ext; frm_rtr = rtr; frm_id = id; frm_dlc = dlc;
      frm_data_lo = lo; frm_data_hi = hi; frm_valid = 1'b1;
      @(negedge clk);
      frm_valid = 1'b0;
   endtask

   task automatic set_mode(input int idx, input logic [2:0] m);
      @(negedge clk);
      mode_idx = idx[3:0]; mode_wdata = {5'd0, m, 24'd0}; mode_wr = 1'b1;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic rearm(input logic [NMB-1:0] m);
      @(negedge clk);
      arm_mask = m; arm_valid = 1'b1;
      @(negedge clk);
      arm_valid = 1'b0;
   endtask

   task automatic rd(input int idx, input logic [2:0] s, output logic [31:0] v);
      rd_idx = idx[3:0]; rd_sel = s;
      #1 v = rd_data;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 ready_vec", 32'(ready_vec), 32'h0);
      check("R1 lost_flag", 32'(lost_flag), 32'h0);
      rd(5, 3'd0, v);
      check("R1 mode mb5", v, 32'h0);
   endtask

   task automatic t_config();
      logic [31:0] v;
      for (int i = 0; i < 11; i++) set_mode(i, 3'd1);
      set_mode(11, 3'd2);
      rd(11, 3'd0, v);
      check("R3 mode readback mb11", v, 32'h0200_0000);
   endtask

   task automatic t_standard();
      logic [31:0] v;
      send(1'b0, 1'b0, 29'h123, 4'd8, 32'h0302_0100, 32'h0706_0504);
      check("R2 first frame to mb0", 32'(ready_vec), 32'h001);
      rd(0, 3'd1, v); check("R4 std id", v, 32'h048C_0000);
      rd(0, 3'd2, v); check("R5 std status", v, 32'h0088_0000);
      rd(0, 3'd3, v); check("R5 data low", v, 32'h0302_0100);
      rd(0, 3'd4, v); check("R5 data high", v, 32'h0706_0504);
   endtask

   task automatic t_extended();
      logic [31:0] v;
      send(1'b1, 1'b1, 29'h1ABC_DEF5, 4'd0, 32'h0, 32'h0);
      check("R10 ready_vec after ext", 32'(ready_vec), 32'h003);
      rd(1, 3'd1, v); check("R4 ext id", v, 32'h3ABC_DEF5);
      rd(1, 3'd2, v); check("R5 rtr status", v, 32'h0090_0000);
   endtask

   task automatic t_lowest();
      logic [31:0] v;
      rearm(12'h001);
      check("R7 single rearm", 32'(ready_vec), 32'h002);
      send(1'b0, 1'b0, 29'h055, 4'd1, 32'h11, 32'h0);
      check("R2 refill lowest mb0", 32'(ready_vec), 32'h003);
      rd(0, 3'd1, v); check("R2 mb0 new id", v, 32'h0154_0000);
      rd(1, 3'd1, v); check("R6 mb1 untouched", v, 32'h3ABC_DEF5);
   endtask

   task automatic t_skip();
      logic [31:0] v;
      set_mode(2, 3'd3);
      set_mode(3, 3'd0);
      send(1'b0, 1'b0, 29'h066, 4'd1, 32'h22, 32'h0);
      check("R3 skip tx and disabled", 32'(ready_vec), 32'h013);
      rd(2, 3'd2, v); check("R3 tx mailbox not ready", v, 32'h0);
   endtask

   task automatic t_overwrite();
      logic [31:0] v;
      for (int i = 0; i < 6; i++) send(1'b0, 1'b0, 29'(i), 4'd1, 32'(i), 32'h0);
      check("R2 fill 5..10", 32'(ready_vec), 32'h7F3);
      send(1'b0, 1'b0, 29'h100, 4'd1, 32'h0, 32'h0);
      check("R2 empty overwrite mb used", 32'(ready_vec), 32'hFF3);
      rd(11, 3'd2, v); check("R8 no ignore on empty", v, 32'h0081_0000);
      send(1'b0, 1'b0, 29'h7FF, 4'd2, 32'hCAFE, 32'h0);
      rd(11, 3'd1, v); check("R8 overwritten id", v, 32'h1FFC_0000);
      rd(11, 3'd2, v); check("R8 ignored flag set", v, 32'h0182_0000);
      check("R8 lost flag clear", 32'(lost_flag), 32'h0);
      rd(0, 3'd1, v); check("R6 mb0 kept", v, 32'h0154_0000);
   endtask

   task automatic t_group_rearm();
      logic [31:0] v;
      rearm(12'h811);
      check("R7 group rearm", 32'(ready_vec), 32'h7E2);
      rd(11, 3'd2, v); check("R7 ignored cleared", v, 32'h0002_0000);
   endtask

   task automatic t_drop();
      logic [31:0] v;
      send(1'b0, 1'b0, 29'h0AA, 4'd1, 32'h0, 32'h0);
      send(1'b0, 1'b0, 29'h0BB, 4'd1, 32'h0, 32'h0);
      send(1'b0, 1'b0, 29'h2AA, 4'd1, 32'h0, 32'h0);
      check("R2 refill after group", 32'(ready_vec), 32'hFF3);
      set_mode(11, 3'd1);
      send(1'b0, 1'b0, 29'h111, 4'd3, 32'hDEAD, 32'h0);
      check("R9 lost set", 32'(lost_flag), 32'h1);
      check("R9 ready unchanged", 32'(ready_vec), 32'hFF3);
      rd(11, 3'd1, v); check("R9 mb11 untouched", v, 32'h0AA8_0000);
      rearm(12'h001);
      check("R9 lost sticky", 32'(lost_flag), 32'h1);
      do_reset();
      check("R1 lost cleared by reset", 32'(lost_flag), 32'h0);
      check("R1 ready cleared by reset", 32'(ready_vec), 32'h0);
   endtask

   initial begin
      do_reset();
      t_reset();
      t_config();
      t_standard();
      t_extended();
      t_lowest();
      t_skip();
      t_overwrite();
      t_group_rearm();
      t_drop();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired got=running exp=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule